// File: doc/BRIEF.md
# Host Port Target with Dual Word Pointers

This block is the slave end of a 16-bit parallel host port. An external host uses it to reach a small internal memory of 32-bit words. On each access strobe, a two-bit select input picks the target. The target is either the control register, the address register, data with post-increment, or data with a fixed pointer. Each 32-bit word crosses the bus in two 16-bit halves, and a half-select input marks which half is being moved.

The address register holds a word index, not a byte address. A byte address is therefore divided by four before it is loaded, and each completed word access in post-increment mode advances the pointer by exactly one. The block keeps one pointer for reads and one for writes. In single mode both pointers move together. In dual mode each pointer can be loaded and read back on its own. The control register also holds a host interrupt flag, which the local side raises with a strobe and the host clears by writing a one, and a ready flag.

A small sequencer with three states tracks the halves. The states are ST_IDLE, ST_WR_HOLD and ST_RD_HOLD. A first-half write moves to ST_WR_HOLD and a first-half read moves to ST_RD_HOLD. From either hold state, another first half restarts into the hold state that matches its direction. A second half returns the sequencer to ST_IDLE. It commits the access only if its direction and select match the held access, and otherwise it is discarded.

Top module: `hostport_target`

## Requirements
- R1: The select encoding is 00 = control, 01 = data with post-increment, 10 = address, 11 = data with fixed pointer. The control register bits are: bit 0 dual mode, bit 1 pointer choice, bit 2 interrupt flag, bit 3 ready, and all higher bits read as 0. After reset, a control read returns 0x0008, hint_n is 1 and both pointers are 0. Control accesses ignore the half-select input.
- R2: A 32-bit write moves its low half with hhalf=0 and its high half with hhalf=1. Memory and the pointers change only when a second half arrives with the same select as the held first half. A second half with no first half pending, or with a different select, changes nothing.
- R3: A pointer value is a word index: a data write with the pointer at k stores the full 32-bit word at word k, and a read at k returns it.
- R4: With select 01, the relevant pointer grows by exactly 1 per completed word: after the second half of a write for the write pointer, and after the second half of a read for the read pointer.
- R5: With select 11, data reads and writes leave both pointers unchanged.
- R6: In single mode (control bit 0 = 0), an address write loads both pointers and any increment moves both.
- R7: In dual mode (control bit 0 = 1), address reads and writes reach the write pointer when control bit 1 = 1 and the read pointer when it is 0, and the two pointers increment independently.
- R8: A one-cycle local strobe sets the interrupt flag (bit 2), and hint_n is 0 while the flag is set. A host control write with bit 2 = 1 clears the flag and a 0 in that bit leaves it unchanged. A local strobe in the same cycle as a clearing write wins.
- R9: The ready bit (bit 3) reads 1 when no half is pending and 0 between the first and second half of an access.
- R10: A word index at or above DEPTH reads as zero and ignores writes. Post-increment still advances past it.
- R11: hrdata is valid the cycle after a read strobe. The second half of a read returns the high half of the word captured at the first half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hstb | input | 1 | Access strobe, one cycle per 16-bit half |
| hwr | input | 1 | 1 = host write, 0 = host read |
| hhalf | input | 1 | 0 = first (low) half, 1 = second (high) half |
| hsel | input | 2 | Target select (see R1) |
| hwdata | input | DW | Host write data |
| hrdata | output | DW | Host read data, registered |
| lcl_int_set | input | 1 | Local strobe that raises the interrupt flag |
| hint_n | output | 1 | Active-low interrupt to the host |

## Verification
The bench builds the block with DEPTH = 8 instead of the default 16. With that depth, the last valid word index (7) and the first invalid one (8) are reached in a few accesses. A write that straddles the boundary, and a check that index 8 does not alias onto word 0, fit into one short scenario. The 16-bit half width is kept, so every 32-bit value used in a test splits into distinct halves, and a swapped or stale half shows up in the compared word.

// File: rtl/hp_pkg.sv
package hp_pkg;

    typedef enum logic [1:0] {
        SEL_CTRL = 2'b00,
        SEL_DINC = 2'b01,
        SEL_ADDR = 2'b10,
        SEL_DFIX = 2'b11
    } hsel_e;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'b00,
        ST_WR_HOLD = 2'b01,
        ST_RD_HOLD = 2'b10
    } phase_e;

endpackage

// File: rtl/hp_seq.sv
module hp_seq
    import hp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hstb,
    input  logic       hwr,
    input  logic       hhalf,
    input  logic [1:0] hsel,
    output phase_e     state,
    output logic [1:0] held_sel,
    output logic       wr_commit,
    output logic       rd_finish
);

    phase_e nxt;
    logic   pair_acc;
    logic   first_h;
    logic   second_h;
    logic   same_sel;

    always_comb begin
        pair_acc = hstb && (hsel != SEL_CTRL);
        first_h  = pair_acc && !hhalf;
        second_h = pair_acc && hhalf;
        same_sel = (hsel == held_sel);
        nxt      = state;
        unique case (state)
            ST_IDLE: begin
                if (first_h) nxt = hwr ? ST_WR_HOLD : ST_RD_HOLD;
            end
            ST_WR_HOLD, ST_RD_HOLD: begin
                if (first_h)       nxt = hwr ? ST_WR_HOLD : ST_RD_HOLD;
                else if (second_h) nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            held_sel <= SEL_CTRL;
        end else begin
            state <= nxt;
            if (first_h) held_sel <= hsel;
        end
    end

    // outputs
    always_comb begin
        wr_commit = (state == ST_WR_HOLD) && second_h && hwr  && same_sel;
        rd_finish = (state == ST_RD_HOLD) && second_h && !hwr && same_sel;
    end

endmodule

// File: rtl/hp_ptrs.sv
module hp_ptrs #(
    parameter int PW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dual,
    input  logic          aptr_sel,
    input  logic          ld,
    input  logic [PW-1:0] ld_val,
    input  logic          inc_r,
    input  logic          inc_w,
    output logic [PW-1:0] rptr,
    output logic [PW-1:0] wptr
);

    logic step_r;
    logic step_w;
    logic load_r;
    logic load_w;

    always_comb begin
        step_r = dual ? inc_r : (inc_r || inc_w);
        step_w = dual ? inc_w : (inc_r || inc_w);
        load_r = ld && (!dual || !aptr_sel);
        load_w = ld && (!dual || aptr_sel);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rptr <= '0;
            wptr <= '0;
        end else begin
            if (load_r)      rptr <= ld_val;
            else if (step_r) rptr <= rptr + PW'(1);
            if (load_w)      wptr <= ld_val;
            else if (step_w) wptr <= wptr + PW'(1);
        end
    end

endmodule

// File: rtl/hp_wordmem.sv
module hp_wordmem #(
    parameter int DEPTH = 16,
    parameter int WW    = 32,
    parameter int PW    = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [PW-1:0] widx,
    input  logic [WW-1:0] wdata,
    input  logic [PW-1:0] ridx,
    output logic [WW-1:0] rdata
);

    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [WW-1:0] words [DEPTH];
    logic          w_ok;
    logic          r_ok;

    always_comb begin
        w_ok  = (widx < PW'(DEPTH));
        r_ok  = (ridx < PW'(DEPTH));
        rdata = r_ok ? words[ridx[IW-1:0]] : '0;
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (!rst_n)
                words[g] <= '0;
            else if (we && w_ok && (widx[IW-1:0] == IW'(g)))
                words[g] <= wdata;
        end
    end

endmodule

// File: rtl/hostport_target.sv
module hostport_target
    import hp_pkg::*;
#(
    parameter int DW    = 16,
    parameter int DEPTH = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hstb,
    input  logic          hwr,
    input  logic          hhalf,
    input  logic [1:0]    hsel,
    input  logic [DW-1:0] hwdata,
    output logic [DW-1:0] hrdata,
    input  logic          lcl_int_set,
    output logic          hint_n
);

    localparam int WW = 2 * DW;
    localparam int PW = 2 * DW;

    phase_e        state;
    logic [1:0]    held_sel;
    logic          wr_commit;
    logic          rd_finish;
    logic [PW-1:0] rptr;
    logic [PW-1:0] wptr;
    logic [WW-1:0] mem_rdata;
    logic [DW-1:0] stage_lo;
    logic [DW-1:0] rd_hi;
    logic          dual;
    logic          aptr_sel;
    logic          int_flag;

    logic          ctrl_wr;
    logic          ctrl_rd;
    logic          first_wr;
    logic          first_rd;
    logic          ld_addr;
    logic          mem_we;
    logic          inc_r;
    logic          inc_w;
    logic [PW-1:0] cur_aptr;
    logic [WW-1:0] rd_word;
    logic [DW-1:0] ctrl_word;

    always_comb begin
        ctrl_wr   = hstb && hwr  && (hsel == SEL_CTRL);
        ctrl_rd   = hstb && !hwr && (hsel == SEL_CTRL);
        first_wr  = hstb && hwr  && !hhalf && (hsel != SEL_CTRL);
        first_rd  = hstb && !hwr && !hhalf && (hsel != SEL_CTRL);
        ld_addr   = wr_commit && (held_sel == SEL_ADDR);
        mem_we    = wr_commit && (held_sel == SEL_DINC || held_sel == SEL_DFIX);
        inc_w     = wr_commit && (held_sel == SEL_DINC);
        inc_r     = rd_finish && (held_sel == SEL_DINC);
        cur_aptr  = (dual && aptr_sel) ? wptr : rptr;
        rd_word   = (hsel == SEL_ADDR) ? cur_aptr : mem_rdata;
        ctrl_word = {{(DW-4){1'b0}}, (state == ST_IDLE), int_flag, aptr_sel, dual};
        hint_n    = !int_flag;
    end

    hp_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .hstb      (hstb),
        .hwr       (hwr),
        .hhalf     (hhalf),
        .hsel      (hsel),
        .state     (state),
        .held_sel  (held_sel),
        .wr_commit (wr_commit),
        .rd_finish (rd_finish)
    );

    hp_ptrs #(.PW(PW)) u_ptrs (
        .clk      (clk),
        .rst_n    (rst_n),
        .dual     (dual),
        .aptr_sel (aptr_sel),
        .ld       (ld_addr),
        .ld_val   ({hwdata, stage_lo}),
        .inc_r    (inc_r),
        .inc_w    (inc_w),
        .rptr     (rptr),
        .wptr     (wptr)
    );

    hp_wordmem #(.DEPTH(DEPTH), .WW(WW), .PW(PW)) u_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .widx  (wptr),
        .wdata ({hwdata, stage_lo}),
        .ridx  (rptr),
        .rdata (mem_rdata)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dual     <= 1'b0;
            aptr_sel <= 1'b0;
            int_flag <= 1'b0;
        end else begin
            if (ctrl_wr) begin
                dual     <= hwdata[0];
                aptr_sel <= hwdata[1];
            end
            if (lcl_int_set)                 int_flag <= 1'b1;
            else if (ctrl_wr && hwdata[2])   int_flag <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_lo <= '0;
            rd_hi    <= '0;
            hrdata   <= '0;
        end else begin
            if (first_wr) stage_lo <= hwdata;
            if (ctrl_rd) begin
                hrdata <= ctrl_word;
            end else if (first_rd) begin
                hrdata <= rd_word[DW-1:0];
                rd_hi  <= rd_word[WW-1:DW];
            end else if (rd_finish) begin
                hrdata <= rd_hi;
            end
        end
    end

endmodule

// File: rtl/hostport_target_chk.sv
module hostport_target_chk #(
    parameter int PW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          hstb,
    input logic          hwr,
    input logic          hhalf,
    input logic [1:0]    hsel,
    input logic          clr_bit,
    input logic          lcl_int_set,
    input logic          hint_n,
    input logic [1:0]    state,
    input logic [PW-1:0] rptr,
    input logic [PW-1:0] wptr
);

    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !(hstb && hwr && hsel == 2'b10) |=> ((rptr == $past(rptr)) || (rptr == $past(rptr) + PW'(1)))); // R4

    AST_FIXED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (hstb && hsel == 2'b11) |=> ($stable(rptr) && $stable(wptr))); // R5

    AST_ORPHAN_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        (hstb && hhalf && hsel != 2'b00 && state == 2'b00) |=> ($stable(rptr) && $stable(wptr))); // R2

    AST_IRQ_SET: assert property (@(posedge clk) disable iff (!rst_n)
        lcl_int_set |=> !hint_n); // R8

    AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (hstb && hwr && hsel == 2'b00 && clr_bit && !lcl_int_set) |=> hint_n); // R8

endmodule

bind hostport_target hostport_target_chk #(.PW(PW)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .hstb        (hstb),
    .hwr         (hwr),
    .hhalf       (hhalf),
    .hsel        (hsel),
    .clr_bit     (hwdata[2]),
    .lcl_int_set (lcl_int_set),
    .hint_n      (hint_n),
    .state       (state),
    .rptr        (rptr),
    .wptr        (wptr)
);

// File: tb/test_hostport_target.sv
`timescale 1ns/1ps
module test_hostport_target;

    localparam int DW    = 16;
    localparam int DEPTH = 8;

    localparam logic [1:0] S_CTRL = 2'b00;
    localparam logic [1:0] S_DINC = 2'b01;
    localparam logic [1:0] S_ADDR = 2'b10;
    localparam logic [1:0] S_DFIX = 2'b11;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          hstb = 1'b0;
    logic          hwr = 1'b0;
    logic          hhalf = 1'b0;
    logic [1:0]    hsel = 2'b00;
    logic [DW-1:0] hwdata = '0;
    logic [DW-1:0] hrdata;
    logic          lcl_int_set = 1'b0;
    logic          hint_n;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    hostport_target #(.DW(DW), .DEPTH(DEPTH)) i_hostport_target (
        .clk         (clk),
        .rst_n       (rst_n),
        .hstb        (hstb),
        .hwr         (hwr),
        .hhalf       (hhalf),
        .hsel        (hsel),
        .hwdata      (hwdata),
        .hrdata      (hrdata),
        .lcl_int_set (lcl_int_set),
        .hint_n      (hint_n)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic acc(input logic [1:0] sel, input logic wr, input logic half,
                       input logic [DW-1:0] d, output logic [DW-1:0] q);
        @(negedge clk);
        hstb = 1'b1; hsel = sel; hwr = wr; hhalf = half; hwdata = d;
        @(negedge clk);
        hstb = 1'b0; hwr = 1'b0; hhalf = 1'b0;
        q = hrdata;
    endtask

    task automatic wr32(input logic [1:0] sel, input logic [31:0] v);
        logic [DW-1:0] q;
        acc(sel, 1'b1, 1'b0, v[15:0], q);
        acc(sel, 1'b1, 1'b1, v[31:16], q);
    endtask

    task automatic rd32(input logic [1:0] sel, output logic [31:0] v);
        logic [DW-1:0] lo;
        logic [DW-1:0] hi;
        acc(sel, 1'b0, 1'b0, '0, lo);
        acc(sel, 1'b0, 1'b1, '0, hi);
        v = {hi, lo};
    endtask

    task automatic wr_ctrl(input logic [DW-1:0] v);
        logic [DW-1:0] q;
        acc(S_CTRL, 1'b1, 1'b0, v, q);
    endtask

    task automatic rd_ctrl(output logic [DW-1:0] v);
        acc(S_CTRL, 1'b0, 1'b1, '0, v);
    endtask

    task automatic t_reset();
        logic [DW-1:0] c;
        logic [31:0] a;
        rd_ctrl(c);
        check("R1 control after reset", 32'(c), 32'h0008);
        check("R1 hint_n after reset", 32'(hint_n), 32'h1);
        rd32(S_ADDR, a);
        check("R1 pointer after reset", a, 32'h0);
    endtask

    task automatic t_autoinc();
        logic [31:0] v;
        wr32(S_ADDR, 32'd3);
        wr32(S_DINC, 32'hAABB_CCDD);
        wr32(S_DINC, 32'h1122_3344);
        rd32(S_ADDR, v);
        check("R4 pointer after two inc writes", v, 32'd5);
        wr32(S_ADDR, 32'd3);
        rd32(S_DINC, v);
        check("R3 word at index 3", v, 32'hAABB_CCDD);
        rd32(S_DINC, v);
        check("R11 word at index 4", v, 32'h1122_3344);
        rd32(S_ADDR, v);
        check("R4 pointer after two inc reads", v, 32'd5);
    endtask

    task automatic t_fixed();
        logic [31:0] v;
        wr32(S_ADDR, 32'd2);
        wr32(S_DFIX, 32'h0101_0202);
        wr32(S_DFIX, 32'h0303_0404);
        rd32(S_ADDR, v);
        check("R5 pointer after fixed writes", v, 32'd2);
        rd32(S_DFIX, v);
        check("R5 fixed overwrite", v, 32'h0303_0404);
        rd32(S_ADDR, v);
        check("R5 pointer after fixed read", v, 32'd2);
    endtask

    task automatic t_halves();
        logic [DW-1:0] q;
        logic [DW-1:0] c;
        logic [31:0] v;
        wr32(S_ADDR, 32'd6);
        acc(S_DFIX, 1'b1, 1'b0, 16'hBEEF, q);
        rd_ctrl(c);
        check("R9 ready low between halves", 32'(c), 32'h0000);
        acc(S_DFIX, 1'b1, 1'b1, 16'hCAFE, q);
        rd_ctrl(c);
        check("R9 ready back high", 32'(c), 32'h0008);
        rd32(S_DFIX, v);
        check("R2 halves assembled", v, 32'hCAFE_BEEF);
        acc(S_DFIX, 1'b1, 1'b1, 16'h1234, q);
        rd32(S_DFIX, v);
        check("R2 orphan second half ignored", v, 32'hCAFE_BEEF);
        acc(S_DFIX, 1'b1, 1'b0, 16'h5678, q);
        acc(S_DINC, 1'b1, 1'b1, 16'h9ABC, q);
        rd32(S_DFIX, v);
        check("R2 mismatched select ignored", v, 32'hCAFE_BEEF);
        rd32(S_ADDR, v);
        check("R2 pointer unchanged by mismatch", v, 32'd6);
    endtask

    task automatic t_dual();
        logic [31:0] v;
        wr_ctrl(16'h0001);
        wr32(S_ADDR, 32'd1);
        wr_ctrl(16'h0003);
        wr32(S_ADDR, 32'd5);
        wr_ctrl(16'h0001);
        rd32(S_ADDR, v);
        check("R7 read pointer readback", v, 32'd1);
        wr_ctrl(16'h0003);
        rd32(S_ADDR, v);
        check("R7 write pointer readback", v, 32'd5);
        wr32(S_DINC, 32'h5555_AAAA);
        rd32(S_ADDR, v);
        check("R7 write pointer advanced", v, 32'd6);
        wr_ctrl(16'h0001);
        rd32(S_ADDR, v);
        check("R7 read pointer untouched", v, 32'd1);
        wr32(S_ADDR, 32'd5);
        rd32(S_DINC, v);
        check("R7 data via read pointer", v, 32'h5555_AAAA);
        rd32(S_ADDR, v);
        check("R7 read pointer advanced", v, 32'd6);
        wr_ctrl(16'h0000);
    endtask

    task automatic t_single();
        logic [31:0] v;
        wr_ctrl(16'h0000);
        wr32(S_ADDR, 32'd4);
        wr_ctrl(16'h0003);
        rd32(S_ADDR, v);
        check("R6 single load reached write pointer", v, 32'd4);
        wr_ctrl(16'h0001);
        rd32(S_ADDR, v);
        check("R6 single load reached read pointer", v, 32'd4);
        wr_ctrl(16'h0000);
        wr32(S_DINC, 32'h0BAD_F00D);
        wr_ctrl(16'h0001);
        rd32(S_ADDR, v);
        check("R6 write increment moved read pointer", v, 32'd5);
        wr_ctrl(16'h0000);
    endtask

    task automatic t_range();
        logic [31:0] v;
        wr32(S_ADDR, 32'd7);
        wr32(S_DINC, 32'h7777_7777);
        wr32(S_DINC, 32'hDEAD_DEAD);
        rd32(S_ADDR, v);
        check("R10 increment past end", v, 32'd9);
        wr32(S_ADDR, 32'd8);
        rd32(S_DFIX, v);
        check("R10 out of range reads zero", v, 32'h0);
        wr32(S_ADDR, 32'd0);
        rd32(S_DFIX, v);
        check("R10 no alias onto word 0", v, 32'h0);
        wr32(S_ADDR, 32'd7);
        rd32(S_DFIX, v);
        check("R10 last word kept", v, 32'h7777_7777);
    endtask

    task automatic t_irq();
        logic [DW-1:0] c;
        @(negedge clk); lcl_int_set = 1'b1;
        @(negedge clk); lcl_int_set = 1'b0;
        check("R8 hint_n low after set", 32'(hint_n), 32'h0);
        rd_ctrl(c);
        check("R8 flag visible at bit 2", 32'(c), 32'h000C);
        wr_ctrl(16'h0000);
        check("R8 writing 0 keeps flag", 32'(hint_n), 32'h0);
        wr_ctrl(16'h0004);
        check("R8 writing 1 clears flag", 32'(hint_n), 32'h1);
        @(negedge clk);
        hstb = 1'b1; hwr = 1'b1; hsel = S_CTRL; hhalf = 1'b0; hwdata = 16'h0004; lcl_int_set = 1'b1;
        @(negedge clk);
        hstb = 1'b0; hwr = 1'b0; lcl_int_set = 1'b0;
        check("R8 set wins over clear", 32'(hint_n), 32'h0);
        wr_ctrl(16'h0004);
        check("R8 final clear", 32'(hint_n), 32'h1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_autoinc();
        t_fixed();
        t_halves();
        t_dual();
        t_single();
        t_range();
        t_irq();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule